// File: doc/BRIEF.md
# Instruction-Controlled Boundary Scan Register

This block is a chain of boundary scan cells placed around a small core logic function. There is one cell for each core input pin, one for each core output pin, and one cell that drives the output enable. Every cell has a shift stage, clocked on the rising TCK edge, and a shadow latch, loaded on the falling TCK edge. A one-bit bypass register sits next to the chain. The test access port controller runs outside the block. It supplies the capture, shift and update data-register strobes and a decoded 3-bit instruction code. The block answers with TDO. It also steers what reaches the core inputs and the output pins, and it drives the pin output enable.

The active instruction sets three things. The first is the scan path: the full chain or the bypass bit. The second is what the chain loads at capture: the pin and core values, its own current contents, or the inverse of the shadow latches. The third is whether the pins and the core run in normal mode, in test mode from the shadow latches, or with the pin drivers forced off. Holding the current contents and capturing the inverse of the shadow latches let software read back the shift stages and the shadow latches separately.

Top module: `bscan_ring`

## Requirements
- R1: While trstN is low, every shift stage and shadow latch clears to 0, except the output-enable cell, which resets to 1 (drivers off). The bypass bit and tdo also clear to 0.
- R2: Codes 0 to 3 select the chain. On a rising TCK edge with shiftDr high and captureDr low, tdi enters input cell 0. Data then passes through input cells 0 to NUM_IN-1, output cells 0 to NUM_OUT-1 and the output-enable cell. On each falling edge tdo takes the value of the output-enable cell's shift stage.
- R3: Codes 4 to 7 select the bypass bit. It loads 0 at capture and loads tdi at shift, and tdo follows it on the falling edge. The chain is left untouched.
- R4: At capture under code 0 (external test) or code 1 (sample), each input cell loads its pinIn bit. Each output cell loads its coreOut bit, and the output-enable cell loads coreOeN.
- R5: At capture under code 2 (read), every shift stage keeps its current value.
- R6: At capture under code 3 (self-test), every shift stage loads the inverse of its own shadow latch.
- R7: The shadow latches load from the shift stages on a falling edge with updateDr high, and only while codes 0 to 3 are active. An update under codes 4 to 7 leaves them unchanged.
- R8: Under codes 0, 5 (clamp) and 6 (run-test) the block is in test mode. In test mode, coreIn equals the input-cell shadows and pinOut equals the output-cell shadows. pinOe is the inverse of the output-enable shadow, which is active low.
- R9: Under codes 1, 2, 3 and 7 (bypass) the block is in normal mode. In normal mode, coreIn equals pinIn, pinOut equals coreOut and pinOe equals the inverse of coreOeN.
- R10: Under code 4 (high impedance), pinOe is 0 while coreIn equals pinIn and pinOut equals coreOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| instrCode | input | 3 | Decoded active instruction |
| captureDr | input | 1 | Capture-DR state strobe |
| shiftDr | input | 1 | Shift-DR state strobe |
| updateDr | input | 1 | Update-DR state strobe |
| pinIn | input | NUM_IN | Values at the device input pins |
| coreIn | output | NUM_IN | Values delivered to the core inputs |
| coreOut | input | NUM_OUT | Core output values |
| coreOeN | input | 1 | Core output enable, active low |
| pinOut | output | NUM_OUT | Values driven to the output pins |
| pinOe | output | 1 | Output driver enable, active high |

## Verification
The bench builds the block with NUM_IN=3 and NUM_OUT=5. This gives an uneven nine-cell chain, so a swap of input and output cells, or an error of one in the cell order, shows up in the captured and shifted words. The short chain keeps every full capture-shift-update scan to about a dozen clocks. That leaves room to run all eight instruction codes in sequence and to check both read-back paths against data scanned in earlier.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    INS_EXTEST   = 3'd0,
    INS_SAMPLE   = 3'd1,
    INS_READ     = 3'd2,
    INS_SELFTEST = 3'd3,
    INS_HIGHZ    = 3'd4,
    INS_CLAMP    = 3'd5,
    INS_RUNTEST  = 3'd6,
    INS_BYPASS   = 3'd7
  } scanInstr_t;

  typedef enum logic [1:0] {
    CAP_PORTS  = 2'd0,
    CAP_KEEP   = 2'd1,
    CAP_INVERT = 2'd2
  } capMode_t;

  typedef struct packed {
    logic     capBsr;
    capMode_t capMode;
    logic     shiftBsr;
    logic     updBsr;
    logic     capByp;
    logic     shiftByp;
    logic     selBsr;
    logic     testMode;
    logic     forceHiz;
  } scanCtl_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic [2:0] instrCode,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output scanCtl_t   ctl
);

  scanInstr_t instr;
  logic       selBsr;
  logic       shiftOnly;

  assign instr     = scanInstr_t'(instrCode);
  assign shiftOnly = shiftDr & ~captureDr;

  always_comb begin
    selBsr = 1'b0;
    ctl    = '0;
    unique case (instr)
      INS_EXTEST:   begin selBsr = 1'b1; ctl.capMode = CAP_PORTS;  ctl.testMode = 1'b1; end
      INS_SAMPLE:   begin selBsr = 1'b1; ctl.capMode = CAP_PORTS;  end
      INS_READ:     begin selBsr = 1'b1; ctl.capMode = CAP_KEEP;   end
      INS_SELFTEST: begin selBsr = 1'b1; ctl.capMode = CAP_INVERT; end
      INS_HIGHZ:    begin ctl.forceHiz = 1'b1; end
      INS_CLAMP:    begin ctl.testMode = 1'b1; end
      INS_RUNTEST:  begin ctl.testMode = 1'b1; end
      INS_BYPASS:   begin end
      default:      begin end
    endcase
    ctl.selBsr   = selBsr;
    ctl.capBsr   = captureDr & selBsr;
    ctl.shiftBsr = shiftOnly & selBsr;
    ctl.updBsr   = updateDr & selBsr;
    ctl.capByp   = captureDr & ~selBsr;
    ctl.shiftByp = shiftOnly & ~selBsr;
  end

  AST_ONE_SCAN_PATH: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({ctl.capBsr, ctl.shiftBsr, ctl.capByp, ctl.shiftByp})); // R3

  AST_HIZ_NOT_TEST: assert property (@(posedge tck) disable iff (!trstN)
    ctl.forceHiz |-> !ctl.testMode && !ctl.selBsr); // R10

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic     tck,
  input  logic     trstN,
  input  logic     capEn,
  input  capMode_t capMode,
  input  logic     shiftEn,
  input  logic     updEn,
  input  logic     parIn,
  input  logic     serIn,
  output logic     stageQ,
  output logic     shadowQ
);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      stageQ <= RST_VAL;
    end else if (capEn) begin
      unique case (capMode)
        CAP_PORTS:  stageQ <= parIn;
        CAP_KEEP:   stageQ <= stageQ;
        CAP_INVERT: stageQ <= ~shadowQ;
        default:    stageQ <= stageQ;
      endcase
    end else if (shiftEn) begin
      stageQ <= serIn;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      shadowQ <= RST_VAL;
    end else if (updEn) begin
      shadowQ <= stageQ;
    end
  end

endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  scanCtl_t           ctl,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic               coreOeN,
  output logic               tdo,
  output logic [NUM_IN-1:0]  coreIn,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               pinOe
);

  localparam int LEN    = NUM_IN + NUM_OUT + 1;
  localparam int OUT_LO = NUM_IN;
  localparam int OUT_HI = NUM_IN + NUM_OUT - 1;
  localparam int OE_IDX = LEN - 1;

  logic [LEN-1:0] capVec;
  logic [LEN-1:0] stageQ;
  logic [LEN-1:0] shadowQ;
  logic           bypassQ;

  assign capVec = {coreOeN, coreOut, pinIn};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic serIn;
    if (i == 0) begin : g_head
      assign serIn = tdi;
    end else begin : g_link
      assign serIn = stageQ[i-1];
    end
    bscan_cell #(
      .RST_VAL((i == OE_IDX) ? 1'b1 : 1'b0)
    ) u_cell (
      .tck     (tck),
      .trstN   (trstN),
      .capEn   (ctl.capBsr),
      .capMode (ctl.capMode),
      .shiftEn (ctl.shiftBsr),
      .updEn   (ctl.updBsr),
      .parIn   (capVec[i]),
      .serIn   (serIn),
      .stageQ  (stageQ[i]),
      .shadowQ (shadowQ[i])
    );
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassQ <= 1'b0;
    end else if (ctl.capByp) begin
      bypassQ <= 1'b0;
    end else if (ctl.shiftByp) begin
      bypassQ <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo <= 1'b0;
    end else begin
      tdo <= ctl.selBsr ? stageQ[OE_IDX] : bypassQ;
    end
  end

  always_comb begin
    if (ctl.testMode) begin
      coreIn = shadowQ[NUM_IN-1:0];
      pinOut = shadowQ[OUT_HI:OUT_LO];
      pinOe  = ~shadowQ[OE_IDX];
    end else begin
      coreIn = pinIn;
      pinOut = coreOut;
      pinOe  = ~coreOeN & ~ctl.forceHiz;
    end
  end

  AST_BYP_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trstN)
    ctl.capByp |=> !bypassQ); // R3

  AST_BYP_LEAVES_CHAIN: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capByp || ctl.shiftByp) |=> $stable(stageQ)); // R3

  AST_READ_HOLDS: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capBsr && ctl.capMode == CAP_KEEP) |=> $stable(stageQ)); // R5

  AST_SELFTEST_INVERTS: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.capBsr && ctl.capMode == CAP_INVERT) |=> stageQ == ~$past(shadowQ)); // R6

  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trstN)
    ctl.shiftBsr |=> stageQ[LEN-1:1] == $past(stageQ[LEN-2:0])); // R2

  AST_SHADOW_HOLD: assert property (@(negedge tck) disable iff (!trstN)
    !ctl.updBsr |=> $stable(shadowQ)); // R7

  AST_TEST_DRIVES_CORE: assert property (@(posedge tck) disable iff (!trstN)
    ctl.testMode |-> coreIn == shadowQ[NUM_IN-1:0]); // R8

  AST_NORMAL_PASSES: assert property (@(posedge tck) disable iff (!trstN)
    !ctl.testMode |-> coreIn == pinIn && pinOut == coreOut); // R9

  AST_HIZ_DRIVERS_OFF: assert property (@(posedge tck) disable iff (!trstN)
    ctl.forceHiz |-> !pinOe); // R10

endmodule

// File: rtl/bscan_ring.sv
module bscan_ring
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  output logic               tdo,
  input  logic [2:0]         instrCode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic               coreOeN,
  output logic [NUM_OUT-1:0] pinOut,
  output logic               pinOe
);

  scanCtl_t ctl;

  bscan_ctrl u_ctrl (
    .tck       (tck),
    .trstN     (trstN),
    .instrCode (instrCode),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .ctl       (ctl)
  );

  bscan_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .ctl     (ctl),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOeN (coreOeN),
    .tdo     (tdo),
    .coreIn  (coreIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

endmodule

// File: tb/test_bscan_ring.sv
`timescale 1ns/1ps
module test_bscan_ring;

  localparam int NI  = 3;
  localparam int NO  = 5;
  localparam int LEN = NI + NO + 1;

  logic          tck = 1'b0;
  logic          trstN;
  logic          tdi;
  logic          tdo;
  logic [2:0]    instr;
  logic          captureDr, shiftDr, updateDr;
  logic [NI-1:0] pinIn;
  logic [NI-1:0] coreIn;
  logic [NO-1:0] coreOut;
  logic          coreOeN;
  logic [NO-1:0] pinOut;
  logic          pinOe;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    finished = 0;
  string curReq = "R1";

  // behavioural reference
  bit mChain[$];
  bit mShadow[LEN];
  bit mByp;
  bit mTdo;

  always #4 tck = ~tck;

  bscan_ring #(.NUM_IN(NI), .NUM_OUT(NO)) i_bscan_ring (
    .tck(tck), .trstN(trstN), .tdi(tdi), .tdo(tdo), .instrCode(instr),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .coreOeN(coreOeN),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic bit usesChain(input logic [2:0] c);
    return c <= 3'd3;
  endfunction

  function automatic bit isTest(input logic [2:0] c);
    return c == 3'd0 || c == 3'd5 || c == 3'd6;
  endfunction

  function automatic bit portVal(input int i);
    if (i < NI) return pinIn[i];
    if (i < NI + NO) return coreOut[i-NI];
    return coreOeN;
  endfunction

  function automatic logic [LEN-1:0] shadowVec();
    logic [LEN-1:0] v;
    for (int i = 0; i < LEN; i++) v[i] = mShadow[i];
    return v;
  endfunction

  function automatic logic [LEN+NI+NO:0] expOut();
    logic [NI-1:0] eCore;
    logic [NO-1:0] ePin;
    logic          eOe;
    if (isTest(instr)) begin
      for (int i = 0; i < NI; i++) eCore[i] = mShadow[i];
      for (int i = 0; i < NO; i++) ePin[i] = mShadow[NI+i];
      eOe = !mShadow[LEN-1];
    end else begin
      eCore = pinIn;
      ePin  = coreOut;
      eOe   = (instr == 3'd4) ? 1'b0 : !coreOeN;
    end
    return {mTdo, eOe, ePin, eCore};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelRise();
    if (captureDr) begin
      if (usesChain(instr)) begin
        for (int i = 0; i < LEN; i++) begin
          if (instr <= 3'd1) mChain[i] = portVal(i);
          else if (instr == 3'd3) mChain[i] = !mShadow[i];
        end
      end else begin
        mByp = 1'b0;
      end
    end else if (shiftDr) begin
      if (usesChain(instr)) begin
        mChain.push_front(tdi);
        void'(mChain.pop_back());
      end else begin
        mByp = tdi;
      end
    end
  endtask

  task automatic modelFall();
    if (updateDr && usesChain(instr))
      for (int i = 0; i < LEN; i++) mShadow[i] = mChain[i];
    mTdo = usesChain(instr) ? mChain[LEN-1] : mByp;
  endtask

  task automatic compareAll();
    logic [LEN+NI+NO:0] act;
    logic [LEN+NI+NO:0] exp;
    act = {tdo, pinOe, pinOut, coreIn};
    exp = expOut();
    check(act === exp, curReq, "per-clock outputs", 32'(act), 32'(exp));
  endtask

  task automatic tick(input bit cap, input bit sh, input bit upd, input bit d);
    captureDr = cap; shiftDr = sh; updateDr = upd; tdi = d;
    @(posedge tck);
    modelRise();
    @(negedge tck);
    modelFall();
    #2;
    compareAll();
  endtask

  // capture, LEN shifts, update; returns captured word as seen on tdo
  task automatic scanDr(input logic [LEN-1:0] data, output logic [LEN-1:0] got);
    tick(1, 0, 0, 0);
    got[LEN-1] = tdo;
    for (int k = 1; k <= LEN; k++) begin
      tick(0, 1, 0, data[LEN-k]);
      if (k < LEN) got[LEN-1-k] = tdo;
    end
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] got;
    logic [LEN-1:0] lastData;
    logic [LEN-1:0] expCap;

    trstN = 0; tdi = 0; instr = 3'd7;
    captureDr = 0; shiftDr = 0; updateDr = 0;
    pinIn = 3'b110; coreOut = 5'b01011; coreOeN = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      mChain.push_back(i == LEN-1);
      mShadow[i] = (i == LEN-1);
    end
    mByp = 0; mTdo = 0;
    #10 trstN = 1;
    #1;
    // R1: reset values visible at the ports
    check(tdo === 1'b0, "R1", "tdo after reset", 32'(tdo), 0);
    instr = 3'd0; #1;
    check({pinOe, pinOut, coreIn} === 9'b0, "R1", "shadows after reset",
          32'({pinOe, pinOut, coreIn}), 0);
    instr = 3'd7; #1;
    check({pinOe, pinOut, coreIn} === {1'b0, coreOut, pinIn}, "R9", "bypass normal",
          32'({pinOe, pinOut, coreIn}), 32'({1'b0, coreOut, pinIn}));

    // sample: capture ports, normal mode, load shadows
    curReq = "R4";
    instr = 3'd1; pinIn = 3'b101; coreOut = 5'b10011; coreOeN = 1'b0;
    lastData = 9'h1A5;
    scanDr(lastData, got);
    expCap = {1'b0, 5'b10011, 3'b101};
    check(got === expCap, "R4", "sample capture", 32'(got), 32'(expCap));
    check(got[0] === 1'b1 && got[LEN-1] === 1'b0, "R2", "chain order ends",
          32'(got), 32'(expCap));
    check(pinOut === coreOut && coreIn === pinIn && pinOe === 1'b1, "R9", "sample normal",
          32'({pinOe, pinOut, coreIn}), 32'({1'b1, coreOut, pinIn}));

    // external test: pins from preloaded shadows
    curReq = "R8";
    instr = 3'd0; #1;
    check({pinOe, pinOut, coreIn} === {~lastData[8], lastData[7:3], lastData[2:0]},
          "R8", "extest drive", 32'({pinOe, pinOut, coreIn}),
          32'({~lastData[8], lastData[7:3], lastData[2:0]}));
    pinIn = 3'b010; coreOut = 5'b01100; coreOeN = 1'b1;
    lastData = 9'h05A;
    scanDr(lastData, got);
    expCap = {1'b1, 5'b01100, 3'b010};
    check(got === expCap, "R4", "extest capture", 32'(got), 32'(expCap));
    check({pinOe, pinOut, coreIn} === {1'b1, lastData[7:3], lastData[2:0]}, "R8",
          "extest after update", 32'({pinOe, pinOut, coreIn}),
          32'({1'b1, lastData[7:3], lastData[2:0]}));

    // read: capture keeps contents, shifted out word equals last scan-in
    curReq = "R5";
    instr = 3'd2; pinIn = 3'b111; coreOut = 5'b11111; coreOeN = 1'b0;
    scanDr(9'h133, got);
    check(got === lastData, "R5", "read hold", 32'(got), 32'(lastData));
    lastData = 9'h133;

    // self-test: capture inverse of shadows
    curReq = "R6";
    instr = 3'd3;
    scanDr(9'h0F0, got);
    check(got === ~lastData, "R6", "selftest inverse", 32'(got), 32'(~lastData));
    check(coreIn === pinIn && pinOut === coreOut, "R9", "selftest normal",
          32'({pinOut, coreIn}), 32'({coreOut, pinIn}));
    lastData = 9'h0F0;

    // high impedance: bypass path, drivers off
    curReq = "R10";
    instr = 3'd4; coreOeN = 1'b0; #1;
    check(pinOe === 1'b0 && coreIn === pinIn && pinOut === coreOut, "R10", "highz",
          32'({pinOe, pinOut, coreIn}), 32'({1'b0, coreOut, pinIn}));
    curReq = "R3";
    tick(0, 1, 0, 1);
    tick(1, 0, 0, 0);
    check(tdo === 1'b0, "R3", "bypass captures zero", 32'(tdo), 0);
    tick(0, 1, 0, 1);
    check(tdo === 1'b1, "R3", "bypass shifts tdi", 32'(tdo), 1);
    tick(0, 1, 0, 0);
    tick(0, 0, 1, 0);

    // clamp: shadows unchanged by update under bypass
    curReq = "R7";
    instr = 3'd5; #1;
    check({pinOe, pinOut, coreIn} === {~lastData[8], lastData[7:3], lastData[2:0]},
          "R7", "clamp shadows kept", 32'({pinOe, pinOut, coreIn}),
          32'({~lastData[8], lastData[7:3], lastData[2:0]}));
    check(shadowVec() === lastData, "R7", "model shadows", 32'(shadowVec()), 32'(lastData));
    curReq = "R8";
    for (int k = 0; k < 4; k++) tick(k == 0, k > 0, k == 3, k[0]);

    // run-test: test mode
    instr = 3'd6; #1;
    check(pinOut === lastData[7:3] && coreIn === lastData[2:0], "R8", "runtest test mode",
          32'({pinOut, coreIn}), 32'(lastData[7:0]));
    tick(0, 0, 0, 0);

    // bypass: normal mode again
    curReq = "R9";
    instr = 3'd7; pinIn = 3'b001; coreOut = 5'b10100; coreOeN = 1'b1; #1;
    check({pinOe, pinOut, coreIn} === {1'b0, 5'b10100, 3'b001}, "R9", "bypass normal",
          32'({pinOe, pinOut, coreIn}), 32'({1'b0, 5'b10100, 3'b001}));
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule